// File: doc/BRIEF.md
# SD Card Clock Generator with Selectable Launch Edge

This block derives the clock sent to an SD card from a faster reference clock. A divider value N sets the card clock period to 2N reference cycles. N of zero passes the reference straight through, but only when the reference itself is no faster than the card clock ceiling (50 MHz by default). Values that would push the card clock above that ceiling are raised to the smallest legal divider. A separate enable starts and stops the card clock. Starting and stopping happen only while the card clock is low, so no shortened pulse ever reaches the card.

The divider value is taken over only while the enable is low and the clock has come to rest. A clock-stable flag drops when a new divider is loaded and rises again two reference cycles later.

A launch strobe tells the data path when to update its outputs. The strobe is high in the reference cycle that ends with a rising card-clock edge when high-speed mode is selected, and with a falling edge in full-speed mode. A data register clocked by the reference and enabled by the strobe therefore changes together with the chosen card-clock edge.

Top module: `sdclk_gen`

## Requirements
- R1: With an effective divider N of 1 or more, the card clock has a period of exactly 2N reference cycles, with N cycles high and N cycles low.
- R2: While the enable is low, the card clock shows no new rising edge. Once the pulse in progress has finished, it stays low.
- R3: The effective divider equals the requested value, except in two cases. A value below MIN = ceil(REF_HZ / (2 * MAX_SD_HZ)) becomes MIN. Zero stays zero only when REF_HZ <= MAX_SD_HZ; otherwise it also becomes MIN.
- R4: A change of the divider input while the enable is high has no effect on the running clock. The new value is taken only while the enable is low and the clock is stopped.
- R5: With an effective divider of 0, the card clock follows the reference clock while enabled: high in the reference high phase, low in the low phase.
- R6: Every high pulse of a divided card clock lasts the full N reference cycles. The clock starts from low and stops only in its low phase.
- R7: The clock-stable output is low in the first two reference cycles after a divider reload and high from the third. It is also low during reset and stays high when no reload occurs.
- R8: With hs_mode = 1, launch_stb is high in exactly those reference cycles at whose end the card clock rises.
- R9: With hs_mode = 0, launch_stb is high in exactly those reference cycles at whose end the card clock falls.
- R10: With an effective divider of 0, launch_stb is high in every reference cycle while the pass-through clock runs.
- R11: During reset the card clock, launch_stb and clock-stable are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | DIV_W | Requested divider N |
| clk_en | input | 1 | Card clock enable |
| hs_mode | input | 1 | 1 = launch on rising card-clock edge, 0 = on falling edge |
| sd_clk | output | 1 | Card clock |
| clk_stable | output | 1 | Divider settled after reload |
| launch_stb | output | 1 | One-cycle data launch strobe |

## Verification
The bench drops the enable at random points, both during a high pulse and during a low pulse. A design that gated carelessly would then show a short high pulse or an extra rising edge after the enable has gone. It also changes the divider in the middle of a run: a design that took the value at once would show a period that is neither the old one nor a clean new one. Strobe placement is compared edge by edge in both speed modes, because a strobe off by one cycle or tied to the wrong edge would launch data half a card period early or late. A second instance with a 200 MHz reference receives divider values 0 and 1, which a design without the ceiling clamp would turn into an over-speed or pass-through clock.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   typedef enum logic {
      LAUNCH_FALL = 1'b0,
      LAUNCH_RISE = 1'b1
   } launch_edge_e;

   // smallest divider keeping ref/(2N) at or below the ceiling
   function automatic int unsigned min_div(input int unsigned ref_hz,
                                           input int unsigned max_hz);
      int unsigned two_max;
      if (max_hz == 0) return 1;
      two_max = 2 * max_hz;
      return (ref_hz + two_max - 1) / two_max;
   endfunction

endpackage

// File: rtl/sdclk_div_sel.sv
module sdclk_div_sel #(
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned MIN_DIV  = 1,
   parameter bit          BYP_OK   = 1'b1,
   parameter int unsigned RST_DIV  = 4,
   parameter int unsigned STAB_DLY = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             clk_en,
   input  logic             run_q,
   output logic [DIV_W-1:0] eff_div,
   output logic             reload,
   output logic             clk_stable
);
   localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
   localparam logic [DIV_W-1:0] RST_V = DIV_W'(RST_DIV);

   logic [DIV_W-1:0]    want;
   logic [STAB_DLY-1:0] settle_q;

   always_comb begin
      if (div_val == '0 && BYP_OK)
         want = '0;
      else if (div_val < MIN_V)
         want = MIN_V;
      else
         want = div_val;
   end

   // take a new divider only while the clock rests
   assign reload = !clk_en && !run_q && (want != eff_div);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         eff_div  <= RST_V;
         settle_q <= '0;
      end else if (reload) begin
         eff_div  <= want;
         settle_q <= '0;
      end else begin
         settle_q <= {settle_q[STAB_DLY-2:0], 1'b1};
      end
   end

   assign clk_stable = settle_q[STAB_DLY-1];

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] eff_div,
   input  logic             reload,
   input  logic             clk_en,
   input  logic             hs_mode,
   input  logic             byp_en_q,
   output logic             run_q,
   output logic             div_q,
   output logic             byp_act,
   output logic             launch_stb
);
   import sdclk_pkg::*;

   logic [DIV_W-1:0] cnt_q;
   logic             tc;
   launch_edge_e     edge_sel;

   assign byp_act  = (eff_div == '0);
   assign tc       = (cnt_q == eff_div - 1'b1);
   assign edge_sel = launch_edge_e'(hs_mode);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         div_q <= 1'b0;
         cnt_q <= '0;
      end else if (reload) begin
         cnt_q <= '0;
      end else if (byp_act) begin
         run_q <= clk_en;
         div_q <= 1'b0;
         cnt_q <= '0;
      end else if (!run_q) begin
         run_q <= clk_en;
         cnt_q <= '0;
      end else if (!clk_en && !div_q) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (tc) begin
         cnt_q <= '0;
         div_q <= ~div_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      if (byp_act)
         launch_stb = byp_en_q;
      else if (!run_q || !tc)
         launch_stb = 1'b0;
      else if (edge_sel == LAUNCH_RISE)
         launch_stb = !div_q && clk_en;
      else
         launch_stb = div_q;
   end

endmodule

// File: rtl/sdclk_bypass_gate.sv
module sdclk_bypass_gate (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic run_req,
   output logic gated_clk,
   output logic en_q
);
   // enable moves only while the reference is low
   always_ff @(negedge clk_ref or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else
         en_q <= run_req;
   end

   assign gated_clk = clk_ref & en_q;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned REF_HZ    = 50_000_000,
   parameter int unsigned MAX_SD_HZ = 50_000_000,
   parameter int unsigned RST_DIV   = 4
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             clk_en,
   input  logic             hs_mode,
   output logic             sd_clk,
   output logic             clk_stable,
   output logic             launch_stb
);
   localparam int unsigned MIN_DIV  = sdclk_pkg::min_div(REF_HZ, MAX_SD_HZ);
   localparam bit          BYP_OK   = (REF_HZ <= MAX_SD_HZ);
   localparam int unsigned DIV_MAX  = (1 << DIV_W) - 1;
   localparam int unsigned STAB_DLY = 2;

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_width
      $error("sdclk_gen: DIV_W out of range");
   end
   if (MAX_SD_HZ == 0 || REF_HZ == 0) begin : g_bad_freq
      $error("sdclk_gen: frequencies must be nonzero");
   end
   if (MIN_DIV > DIV_MAX) begin : g_bad_min
      $error("sdclk_gen: divider too narrow for the frequency ceiling");
   end
   if (RST_DIV < MIN_DIV || RST_DIV > DIV_MAX) begin : g_bad_rst
      $error("sdclk_gen: reset divider out of range");
   end

   logic [DIV_W-1:0] eff_div;
   logic             reload;
   logic             run_q;
   logic             div_q;
   logic             byp_act;
   logic             byp_clk;
   logic             byp_en_q;

   sdclk_div_sel #(
      .DIV_W   (DIV_W),
      .MIN_DIV (MIN_DIV),
      .BYP_OK  (BYP_OK),
      .RST_DIV (RST_DIV),
      .STAB_DLY(STAB_DLY)
   ) u_sel (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .div_val   (div_val),
      .clk_en    (clk_en),
      .run_q     (run_q),
      .eff_div   (eff_div),
      .reload    (reload),
      .clk_stable(clk_stable)
   );

   sdclk_div_core #(
      .DIV_W(DIV_W)
   ) u_core (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .eff_div   (eff_div),
      .reload    (reload),
      .clk_en    (clk_en),
      .hs_mode   (hs_mode),
      .byp_en_q  (byp_en_q),
      .run_q     (run_q),
      .div_q     (div_q),
      .byp_act   (byp_act),
      .launch_stb(launch_stb)
   );

   if (BYP_OK) begin : g_byp
      sdclk_bypass_gate u_gate (
         .clk_ref  (clk_ref),
         .rst_n    (rst_n),
         .run_req  (run_q & byp_act),
         .gated_clk(byp_clk),
         .en_q     (byp_en_q)
      );
   end else begin : g_nobyp
      assign byp_clk  = 1'b0;
      assign byp_en_q = 1'b0;
   end

   assign sd_clk = byp_act ? byp_clk : div_q;

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned MIN_DIV = 1,
   parameter bit          BYP_OK  = 1'b1
) (
   input logic             clk_ref,
   input logic             rst_n,
   input logic             clk_en,
   input logic             hs_mode,
   input logic             run_q,
   input logic             div_q,
   input logic             byp_act,
   input logic             reload,
   input logic             clk_stable,
   input logic             launch_stb,
   input logic [DIV_W-1:0] eff_div
);
   localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

   assert_div_frozen_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !$stable(eff_div) |-> (!$past(clk_en) && !$past(run_q)));

   assert_rise_needs_en_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(div_q) |-> $past(clk_en));

   assert_start_low_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ($rose(run_q) || $fell(run_q)) |-> !div_q);

   assert_reload_drop_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      reload |=> !clk_stable);

   assert_ceiling_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (eff_div == '0) ? BYP_OK : (eff_div >= MIN_V));

   assert_launch_rise_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (launch_stb && hs_mode && !byp_act) |=> $rose(div_q));

   assert_launch_fall_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (launch_stb && !hs_mode && !byp_act) |=> $fell(div_q));

endmodule

bind sdclk_gen sdclk_gen_chk #(
   .DIV_W  (DIV_W),
   .MIN_DIV(MIN_DIV),
   .BYP_OK (BYP_OK)
) chk_i (
   .clk_ref   (clk_ref),
   .rst_n     (rst_n),
   .clk_en    (clk_en),
   .hs_mode   (hs_mode),
   .run_q     (run_q),
   .div_q     (div_q),
   .byp_act   (byp_act),
   .reload    (reload),
   .clk_stable(clk_stable),
   .launch_stb(launch_stb),
   .eff_div   (eff_div)
);

// File: tb/sdclk_gen_tb_top.sv
`timescale 1ns/1ps
module sdclk_gen_tb_top;
   localparam int DW = 8;
   localparam int REF_SLOW = 50_000_000;
   localparam int REF_FAST = 200_000_000;
   localparam int SD_MAX   = 50_000_000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] div_val = 8'd4;
   logic          clk_en = 1'b0;
   logic          hs_mode = 1'b0;
   logic          sd_i, st_i, ls_i, sd_f, st_f, ls_f;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   always #4 clk = ~clk;

   sdclk_gen #(.DIV_W(DW), .REF_HZ(REF_SLOW), .MAX_SD_HZ(SD_MAX), .RST_DIV(4)) dut_i (
      .clk_ref(clk), .rst_n(rst_n), .div_val(div_val), .clk_en(clk_en), .hs_mode(hs_mode),
      .sd_clk(sd_i), .clk_stable(st_i), .launch_stb(ls_i));

   sdclk_gen #(.DIV_W(DW), .REF_HZ(REF_FAST), .MAX_SD_HZ(SD_MAX), .RST_DIV(4)) dut_fast_i (
      .clk_ref(clk), .rst_n(rst_n), .div_val(div_val), .clk_en(clk_en), .hs_mode(hs_mode),
      .sd_clk(sd_f), .clk_stable(st_f), .launch_stb(ls_f));

   // effective divider per R3
   function automatic int exp_div(input int raw, input int ref_hz, input int max_hz);
      int lo;
      lo = (ref_hz + 2 * max_hz - 1) / (2 * max_hz);
      if (raw == 0 && ref_hz <= max_hz) return 0;
      if (raw < lo) return lo;
      return raw;
   endfunction

   task automatic check(input string tag, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // returns 2 ns after a rising reference edge; samples go 1 ns later
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic measure(input int cycles, input int dis_at, input bit hs,
                          input int n0, input int n1, input int chg_at,
                          input logic [DW-1:0] chg_val);
      int   hi[2], lo[2], rises[2], hi_err[2], lo_err[2], stb_err[2], late[2];
      logic prev[2], pstb[2];
      logic cur, stb, rose, fell, sel;
      int   n;
      for (int d = 0; d < 2; d++) begin
         hi[d] = 0; lo[d] = 0; rises[d] = 0; hi_err[d] = 0; lo_err[d] = 0;
         stb_err[d] = 0; late[d] = 0; prev[d] = 1'b0; pstb[d] = 1'b0;
      end
      for (int c = 0; c < cycles; c++) begin
         step();
         if (c == dis_at) clk_en = 1'b0;
         if (c == chg_at) div_val = chg_val;
         #1;
         for (int d = 0; d < 2; d++) begin
            n   = (d == 0) ? n0 : n1;
            cur = (d == 0) ? sd_i : sd_f;
            stb = (d == 0) ? ls_i : ls_f;
            if (n != 0) begin
               rose = cur && !prev[d];
               fell = !cur && prev[d];
               sel  = hs ? rose : fell;
               if (pstb[d] != sel) stb_err[d]++;
               if (rose) begin
                  if (rises[d] > 0 && lo[d] != n) lo_err[d]++;
                  rises[d]++;
                  if (dis_at >= 0 && c > dis_at) late[d]++;
                  hi[d] = 1;
               end else if (cur) hi[d]++;
               if (fell) begin
                  if (hi[d] != n) hi_err[d]++;
                  lo[d] = 1;
               end else if (!cur) lo[d]++;
            end
            prev[d] = cur;
            pstb[d] = stb;
         end
      end
      for (int d = 0; d < 2; d++) begin
         n = (d == 0) ? n0 : n1;
         if (n != 0) begin
            if (d == 0) check("R1 period of divided clock", lo_err[d] == 0 && rises[d] >= 2, lo_err[d], 0);
            else        check("R3 clamped divider period (fast ref)", lo_err[d] == 0 && rises[d] >= 2, lo_err[d], 0);
            check("R6 full high pulses", hi_err[d] == 0, hi_err[d], 0);
            if (hs) check("R8 strobe before rising edge", stb_err[d] == 0, stb_err[d], 0);
            else    check("R9 strobe before falling edge", stb_err[d] == 0, stb_err[d], 0);
            if (dis_at >= 0)
               check("R2 no rise after disable, ends low", late[d] == 0 && prev[d] == 1'b0, late[d], 0);
            if (chg_at >= 0 && d == 0)
               check("R4 divider change while running ignored", lo_err[d] == 0 && hi_err[d] == 0, lo_err[d] + hi_err[d], 0);
         end
      end
   endtask

   initial begin
      int applied, raw, n0, n1, mx, dis, chg, cyc;
      bit hs;
      logic [DW-1:0] cv;
      void'($urandom(32'd31415));
      repeat (3) step();
      #1;
      check("R11 reset sd_clk low", sd_i == 1'b0 && sd_f == 1'b0, sd_i, 0);
      check("R11 reset strobe low", ls_i == 1'b0 && ls_f == 1'b0, ls_i, 0);
      check("R7 stable low in reset", st_i == 1'b0, st_i, 0);
      step();
      rst_n = 1'b1;
      repeat (4) step();
      #1;
      check("R7 stable after reset", st_i == 1'b1, st_i, 1);
      applied = 4;

      for (int t = 0; t < 34; t++) begin
         case (t)
            0: raw = 1;
            1: raw = 2;
            2: raw = 0;
            3: raw = 255;
            4: raw = 1;
            5: raw = 3;
            default: raw = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % 12);
         endcase
         hs = (t < 6) ? t[0] : 1'($urandom);
         step();
         div_val = DW'(raw);
         hs_mode = hs;
         for (int k = 0; k < 3; k++) begin
            step();
            #1;
            if (exp_div(raw, REF_SLOW, SD_MAX) != exp_div(applied, REF_SLOW, SD_MAX))
               check("R7 stable after reload", st_i == (k == 2), st_i, (k == 2) ? 1 : 0);
            else
               check("R7 stable held without reload", st_i == 1'b1, st_i, 1);
         end
         n0 = exp_div(raw, REF_SLOW, SD_MAX);
         n1 = exp_div(raw, REF_FAST, SD_MAX);
         mx = (n0 > n1) ? n0 : n1;
         clk_en = 1'b1;
         if (n0 == 0) begin
            repeat (4) step();
            #1;
            check("R5 pass-through high phase", sd_i == 1'b1, sd_i, 1);
            check("R10 strobe in pass-through", ls_i == 1'b1, ls_i, 1);
            #2;
            check("R5 pass-through low phase", sd_i == 1'b0, sd_i, 0);
         end
         dis = 6 * mx + 3 + ($urandom % (2 * mx));
         chg = ((t % 3) == 1) ? dis / 2 : -1;
         cv  = DW'(1 + ((raw + 3) % 20));
         cyc = dis + 2 * mx + 8;
         measure(cyc, dis, hs, n0, n1, chg, cv);
         if (n0 == 0) begin
            step();
            #1;
            check("R2 pass-through stopped", sd_i == 1'b0, sd_i, 0);
         end
         applied = (chg >= 0) ? int'(cv) : raw;
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule